// File: doc/BRIEF.md
# I2C bit-rate and hold-time generator

This block paces the clock line of an I2C master and times the moments at which the data line may move. A single 8-bit rate setting selects the timing. Its upper two bits are a scaling code and its lower six bits are an index. The index is driven out to a lookup port. Logic outside the block answers with four raw counts: a clock divider, a data-hold count, a start-hold count and a stop-hold count. All four counts are scaled by the same factor of 1, 2 or 4, and the block counts bus clocks against the scaled results.

A start request pulls the block's data-line level low while the clock line is high. It releases the clock into a free-running low/high cycle after the scaled start hold. The block emits a one-cycle strobe after each clock falling edge, once the scaled data hold has elapsed, which tells the byte shifter that SDA may now change. A stop request is honoured at the end of the current low phase. The clock line goes high, and after the scaled stop hold the data-line level is released and the block becomes idle again. If the rate setting is written during a transfer, the write is parked and takes effect when the stop completes.

Top module: `i2c_rate_gen`

## Requirements
- R1: Bits 7..6 of the rate setting are the scaling code and bits 5..0 are the index; the active index is always driven on `rate_idx`.
- R2: Scaling code 0 gives a factor of 1, code 1 a factor of 2, code 2 a factor of 4, and `mul_err` stays low for these codes.
- R3: Scaling code 3 is treated as a factor of 1 and sets `mul_err`, which stays high until reset.
- R4: While running, the clock line repeats with a period of factor × divider bus clocks, measured from falling edge to falling edge.
- R5: The high phase lasts floor(period/2) clocks and the low phase lasts the rest, so an odd period gives the extra clock to the low phase.
- R6: `sda_chg` is a one-cycle pulse that appears factor × data-hold clocks after every falling edge of the clock line.
- R7: `cmd_start` while idle drives `sda_o` low at the next clock edge with `scl_o` high, and `scl_o` falls factor × start-hold clocks later.
- R8: `cmd_stop` during a transfer takes effect at the end of the current low phase: `scl_o` rises, `sda_o` rises factor × stop-hold clocks later, and the block is idle with both lines high.
- R9: A rate write while idle becomes active at the next edge. A write during a transfer leaves the active setting unchanged until the stop completes, and then the last value written is applied.
- R10: After reset, `scl_o` and `sda_o` are high, `sda_chg` and `mul_err` are low, and the active setting is 0.
- R11: `cmd_start` during a transfer and `cmd_stop` while idle have no effect on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_wr | input | 1 | Write strobe for the rate setting |
| freq_wdata | input | 8 | Rate setting: scaling code in [7:6], index in [5:0] |
| cmd_start | input | 1 | Request a start condition |
| cmd_stop | input | 1 | Request a stop condition |
| rate_idx | output | 6 | Active index presented to the lookup |
| lut_div | input | DIV_W | Clock divider for `rate_idx` |
| lut_sda_hold | input | HOLD_W | Raw data-hold count |
| lut_start_hold | input | HOLD_W | Raw start-hold count |
| lut_stop_hold | input | HOLD_W | Raw stop-hold count |
| scl_o | output | 1 | Clock line level |
| sda_o | output | 1 | Data-line level for start and stop |
| sda_chg | output | 1 | Pulse: the data line may change now |
| mul_err | output | 1 | Sticky flag for the reserved scaling code |

## Verification
The bench builds the block with DIV_W=8 and HOLD_W=6. These widths are small enough that the lookup can be an arithmetic function of the index, and wide enough that the scaled counts reach factor 4 without truncation. The lookup gives odd and even dividers and hold counts from 1 to 7. This brings within reach odd periods that split unevenly, a data hold that ends near the low-phase boundary, and every scaling code including the reserved one. A deferred write whose scaling code differs from the running one checks that the new setting waits for the stop.

// File: rtl/i2c_rate_pkg.sv
// Shared definitions for the I2C rate generator.
// Assumes the 8-bit rate setting layout: code in [7:6], index in [5:0].
package i2c_rate_pkg;

    localparam int FREQ_W    = 8;
    localparam int IDX_W     = 6;
    localparam int NUM_HOLDS = 3;
    localparam int HOLD_SDA   = 0;
    localparam int HOLD_START = 1;
    localparam int HOLD_STOP  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STOP
    } seq_state_t;

    // Left-shift amount for a scaling code; the reserved code acts as x1.
    function automatic logic [1:0] mul_shift(input logic [1:0] code);
        case (code)
            2'b01:   return 2'd1;
            2'b10:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic code_reserved(input logic [1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/i2c_rate_scale.sv
// Scales the raw divider and the three raw hold counts by the factor that
// the scaling code selects, and splits the period into high and low phases.
// Assumes the counts fit CNT_W bits after a shift of up to two places.
module i2c_rate_scale
    import i2c_rate_pkg::*;
#(
    parameter int DIV_W  = 10,
    parameter int HOLD_W = 8,
    parameter int CNT_W  = DIV_W + 2
) (
    input  logic [1:0]                         mul_code,
    input  logic [DIV_W-1:0]                   div_raw,
    input  logic [NUM_HOLDS-1:0][HOLD_W-1:0]   hold_raw,
    output logic [CNT_W-1:0]                   period,
    output logic [CNT_W-1:0]                   hi_len,
    output logic [CNT_W-1:0]                   lo_len,
    output logic [NUM_HOLDS-1:0][CNT_W-1:0]    hold_len
);

    logic [1:0] sh;

    // Purpose: period scaling and the phase split (extra clock goes low).
    always_comb begin
        sh     = mul_shift(mul_code);
        period = CNT_W'(div_raw) << sh;
        hi_len = period >> 1;
        lo_len = period - hi_len;
    end

    // One identical scaler per hold count.
    for (genvar g = 0; g < NUM_HOLDS; g++) begin : g_hold
        assign hold_len[g] = CNT_W'(hold_raw[g]) << sh;
    end

endmodule

// File: rtl/i2c_rate_cfg.sv
// Holds the active rate setting and a parked copy for writes that arrive
// during a transfer. Raises a sticky flag when the reserved code is loaded.
// Assumes idle and done come from the sequencer of the same block.
module i2c_rate_cfg
    import i2c_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [FREQ_W-1:0] wdata,
    input  logic              idle,
    input  logic              done,
    output logic [FREQ_W-1:0] act,
    output logic              err
);

    logic [FREQ_W-1:0] pend_q;
    logic              pend_v;
    logic              load;
    logic [FREQ_W-1:0] load_val;

    // Purpose: choose what, if anything, becomes active at this edge.
    always_comb begin
        load     = 1'b0;
        load_val = act;
        if (wr && idle) begin
            load     = 1'b1;
            load_val = wdata;
        end else if (done) begin
            load     = wr || pend_v;
            load_val = wr ? wdata : pend_q;
        end
    end

    // Purpose: active setting and sticky reserved-code flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= '0;
            err <= 1'b0;
        end else if (load) begin
            act <= load_val;
            err <= err | code_reserved(load_val[FREQ_W-1 -: 2]);
        end
    end

    // Purpose: park a write made during a transfer until the stop ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (done) begin
            pend_v <= 1'b0;
        end else if (wr && !idle) begin
            pend_q <= wdata;
            pend_v <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_rate_seq.sv
// Sequences start, the free-running clock and stop. All lengths arrive
// already scaled and must be at least 1 (the period at least 2).
module i2c_rate_seq
    import i2c_rate_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    input  logic [CNT_W-1:0] sta_len,
    input  logic [CNT_W-1:0] sto_len,
    output logic             scl,
    output logic             sda,
    output logic             idle,
    output logic             done,
    output logic             scl_fall
);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             stop_pend;
    logic             stop_go;

    // Purpose: decode terminal count and edge events for neighbours.
    always_comb begin
        cnt_zero = cnt == '0;
        stop_go  = stop_pend | cmd_stop;
        idle     = state == ST_IDLE;
        done     = (state == ST_STOP) && cnt_zero;
        scl_fall = cnt_zero && ((state == ST_START) || (state == ST_HIGH));
    end

    // Purpose: state, phase counter and line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            scl   <= 1'b1;
            sda   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        state <= ST_START;
                        sda   <= 1'b0;
                        cnt   <= sta_len - 1'b1;
                    end
                end
                ST_START: begin
                    if (cnt_zero) begin
                        state <= ST_LOW;
                        scl   <= 1'b0;
                        cnt   <= lo_len - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_LOW: begin
                    if (cnt_zero) begin
                        scl <= 1'b1;
                        if (stop_go) begin
                            state <= ST_STOP;
                            cnt   <= sto_len - 1'b1;
                        end else begin
                            state <= ST_HIGH;
                            cnt   <= hi_len - 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (cnt_zero) begin
                        state <= ST_LOW;
                        scl   <= 1'b0;
                        cnt   <= lo_len - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt_zero) begin
                        state <= ST_IDLE;
                        sda   <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    scl   <= 1'b1;
                    sda   <= 1'b1;
                end
            endcase
        end
    end

    // Purpose: remember a stop request until the low phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_pend <= 1'b0;
        end else if (state == ST_IDLE || state == ST_STOP) begin
            stop_pend <= 1'b0;
        end else if (cmd_stop) begin
            stop_pend <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_rate_holdtmr.sv
// Counts the scaled data hold from each clock falling edge and emits a
// one-cycle strobe when it has elapsed. A new falling edge restarts it.
// Assumes the hold length is at least 1.
module i2c_rate_holdtmr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_fall,
    input  logic [CNT_W-1:0] hold_len,
    output logic             strobe
);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Purpose: hold countdown and strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= active && (cnt == '0);
            if (scl_fall) begin
                active <= 1'b1;
                cnt    <= hold_len - 1'b1;
            end else if (active) begin
                if (cnt == '0) begin
                    active <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_rate_gen.sv
// Top of the I2C bit-rate and hold-time generator. Presents the active index
// to an outside lookup, scales its answers and times the clock line, start,
// stop and the data-change strobe. Assumes the lookup answers in the same
// cycle, the divider is at least 2, every hold is at least 1 and HOLD_W <= DIV_W.
module i2c_rate_gen
    import i2c_rate_pkg::*;
#(
    parameter int DIV_W  = 10,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freq_wr,
    input  logic [7:0]        freq_wdata,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    output logic [5:0]        rate_idx,
    input  logic [DIV_W-1:0]  lut_div,
    input  logic [HOLD_W-1:0] lut_sda_hold,
    input  logic [HOLD_W-1:0] lut_start_hold,
    input  logic [HOLD_W-1:0] lut_stop_hold,
    output logic              scl_o,
    output logic              sda_o,
    output logic              sda_chg,
    output logic              mul_err
);

    localparam int CNT_W = DIV_W + 2;

    logic [FREQ_W-1:0]                freq_act;
    logic                             seq_idle;
    logic                             seq_done;
    logic                             seq_fall;
    logic [NUM_HOLDS-1:0][HOLD_W-1:0] hold_raw;
    logic [NUM_HOLDS-1:0][CNT_W-1:0]  hold_len;
    logic [CNT_W-1:0]                 period;
    logic [CNT_W-1:0]                 hi_len;
    logic [CNT_W-1:0]                 lo_len;

    assign rate_idx = freq_act[IDX_W-1:0];

    // Purpose: gather the raw holds in the scaler's index order.
    always_comb begin
        hold_raw[HOLD_SDA]   = lut_sda_hold;
        hold_raw[HOLD_START] = lut_start_hold;
        hold_raw[HOLD_STOP]  = lut_stop_hold;
    end

    i2c_rate_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (freq_wr),
        .wdata (freq_wdata),
        .idle  (seq_idle),
        .done  (seq_done),
        .act   (freq_act),
        .err   (mul_err)
    );

    i2c_rate_scale #(
        .DIV_W  (DIV_W),
        .HOLD_W (HOLD_W),
        .CNT_W  (CNT_W)
    ) u_scale (
        .mul_code (freq_act[FREQ_W-1 -: 2]),
        .div_raw  (lut_div),
        .hold_raw (hold_raw),
        .period   (period),
        .hi_len   (hi_len),
        .lo_len   (lo_len),
        .hold_len (hold_len)
    );

    i2c_rate_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .sta_len   (hold_len[HOLD_START]),
        .sto_len   (hold_len[HOLD_STOP]),
        .scl       (scl_o),
        .sda       (sda_o),
        .idle      (seq_idle),
        .done      (seq_done),
        .scl_fall  (seq_fall)
    );

    i2c_rate_holdtmr #(
        .CNT_W (CNT_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_fall (seq_fall),
        .hold_len (hold_len[HOLD_SDA]),
        .strobe   (sda_chg)
    );

endmodule

// File: rtl/i2c_rate_gen_chk.sv
// Property checker for i2c_rate_gen, attached by bind. Observes the line
// levels, the strobe, the sticky flag and the sequencer/config hand-off.
module i2c_rate_gen_chk #(
    parameter int DIV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_o,
    input logic             sda_o,
    input logic             sda_chg,
    input logic             mul_err,
    input logic             idle,
    input logic             done,
    input logic [7:0]       act,
    input logic [DIV_W-1:0] lut_div
);

    // R7: the data line only falls while the clock line is high.
    p_start_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_o) |-> scl_o);

    // R8: the data line rises only after the clock line was already high.
    p_stop_scl_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_o) |-> (scl_o && $past(scl_o)));

    // R8: an idle block leaves both lines released.
    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (scl_o && sda_o));

    // R6: the data-change strobe lasts one cycle.
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg |=> !sda_chg);

    // R9: the active setting stays put during a transfer.
    p_cfg_held_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !done) |=> $stable(act));

    // R3: the reserved-code flag never clears without reset.
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mul_err |=> mul_err);

    // R4: a running clock needs a divider of at least two.
    p_div_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (lut_div >= DIV_W'(2)));

endmodule

bind i2c_rate_gen i2c_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .sda_chg (sda_chg),
    .mul_err (mul_err),
    .idle    (seq_idle),
    .done    (seq_done),
    .act     (freq_act),
    .lut_div (lut_div)
);

// File: tb/i2c_rate_gen_test.sv
`timescale 1ns/1ps
module i2c_rate_gen_test;

    localparam int DW = 8;
    localparam int HW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          freq_wr = 1'b0;
    logic [7:0]    freq_wdata = '0;
    logic          cmd_start = 1'b0;
    logic          cmd_stop = 1'b0;
    logic [5:0]    rate_idx;
    logic [DW-1:0] lut_div;
    logic [HW-1:0] lut_sda_hold, lut_start_hold, lut_stop_hold;
    logic          scl_o, sda_o, sda_chg, mul_err;

    always #2.5 clk = ~clk;

    // Bench-side lookup, an arithmetic function of the index.
    function automatic int f_div(input int i);  return 6 + i;     endfunction
    function automatic int f_sdah(input int i); return 1 + i % 2; endfunction
    function automatic int f_sta(input int i);  return 2 + i % 4; endfunction
    function automatic int f_sto(input int i);  return 3 + i % 5; endfunction
    function automatic int f_mul(input int c);
        return (c == 1) ? 2 : (c == 2) ? 4 : 1;
    endfunction

    assign lut_div        = DW'(f_div(int'(rate_idx)));
    assign lut_sda_hold   = HW'(f_sdah(int'(rate_idx)));
    assign lut_start_hold = HW'(f_sta(int'(rate_idx)));
    assign lut_stop_hold  = HW'(f_sto(int'(rate_idx)));

    i2c_rate_gen #(.DIV_W(DW), .HOLD_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr), .freq_wdata(freq_wdata),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .rate_idx(rate_idx),
        .lut_div(lut_div), .lut_sda_hold(lut_sda_hold),
        .lut_start_hold(lut_start_hold), .lut_stop_hold(lut_stop_hold),
        .scl_o(scl_o), .sda_o(sda_o), .sda_chg(sda_chg), .mul_err(mul_err)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       cyc = 0;
    int       mode = 0;          // 0 idle, 1 start hold, 2 running, 3 stop hold
    bit       hp = 1'b0;         // in high phase
    bit       m_scl = 1'b1, m_sda = 1'b1, m_chg = 1'b0, m_err = 1'b0;
    bit       m_stopreq = 1'b0, m_pv = 1'b0;
    logic [7:0] m_act = '0, m_pend = '0;
    int       t_next = 0, t_chg = -1;
    int       sT = 2, sHi = 1, sLo = 1, sChg = 1, sSta = 1, sSto = 1;

    function automatic void m_load(input logic [7:0] v);
        m_act = v;
        if (v[7:6] == 2'b11) m_err = 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; mode = 0; hp = 0; m_scl = 1; m_sda = 1; m_chg = 0;
            m_err = 0; m_stopreq = 0; m_pv = 0; m_act = '0; m_pend = '0;
            t_chg = -1; t_next = 0;
        end else begin
            int  mode_b;
            bit  done;
            mode_b = mode;
            done   = 1'b0;
            cyc++;
            m_chg = (cyc == t_chg);
            if (cmd_stop && (mode == 1 || mode == 2)) m_stopreq = 1'b1;
            case (mode)
                0: if (cmd_start) begin
                    int m, i;
                    m = f_mul(int'(m_act[7:6])); i = int'(m_act[5:0]);
                    sT = m * f_div(i); sHi = sT / 2; sLo = sT - sHi;
                    sChg = m * f_sdah(i); sSta = m * f_sta(i); sSto = m * f_sto(i);
                    m_sda = 0; mode = 1; t_next = cyc + sSta;
                end
                1: if (cyc == t_next) begin
                    m_scl = 0; mode = 2; hp = 0;
                    t_next = cyc + sLo; t_chg = cyc + sChg;
                end
                2: if (cyc == t_next) begin
                    if (!hp) begin
                        m_scl = 1;
                        if (m_stopreq) begin mode = 3; t_next = cyc + sSto; end
                        else begin hp = 1; t_next = cyc + sHi; end
                    end else begin
                        m_scl = 0; hp = 0;
                        t_next = cyc + sLo; t_chg = cyc + sChg;
                    end
                end
                default: if (cyc == t_next) begin
                    m_sda = 1; mode = 0; m_stopreq = 0; done = 1;
                end
            endcase
            if (freq_wr && mode_b == 0) m_load(freq_wdata);
            else if (done) begin
                if (freq_wr) m_load(freq_wdata);
                else if (m_pv) m_load(m_pend);
                m_pv = 0;
            end else if (freq_wr) begin
                m_pend = freq_wdata; m_pv = 1;
            end
        end
    end

    // ------------- per-clock compare and interval monitor -------------
    bit p_scl = 1'b1, p_sda = 1'b1;
    int tf = -1, tr = 0, tsf = 0, n_falls = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk({scl_o, sda_o, sda_chg, mul_err, rate_idx} ==
                {m_scl, m_sda, m_chg, m_err, m_act[5:0]},
                "R4/R5/R6/R7/R8/R11", "model compare",
                int'({scl_o, sda_o, sda_chg, mul_err, rate_idx}),
                int'({m_scl, m_sda, m_chg, m_err, m_act[5:0]}));
            if (p_sda && !sda_o) begin tsf = cyc; tf = -1; end
            if (p_scl && !scl_o) begin
                if (tf < 0) chk(cyc - tsf == sSta, "R7", "start hold", cyc - tsf, sSta);
                else begin
                    chk(cyc - tf == sT, "R4", "scl period", cyc - tf, sT);
                    chk(cyc - tr == sHi, "R5", "high phase", cyc - tr, sHi);
                end
                tf = cyc; n_falls++;
            end
            if (!p_scl && scl_o && tf >= 0) begin
                chk(cyc - tf == sLo, "R5", "low phase", cyc - tf, sLo);
                tr = cyc;
            end
            if (sda_chg) chk(cyc - tf == sChg, "R6", "sda hold", cyc - tf, sChg);
            if (!p_sda && sda_o) chk(cyc - tr == sSto, "R8", "stop hold", cyc - tr, sSto);
        end
        p_scl = scl_o; p_sda = sda_o;
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic wr_freq(input logic [7:0] v);
        @(negedge clk); freq_wr = 1; freq_wdata = v;
        @(negedge clk); freq_wr = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); cmd_start = 1; @(negedge clk); cmd_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && mode != 0; k++) tick(1);
        tick(3);
    endtask

    task automatic xfer(input int periods);
        pulse_start();
        tick(sSta + periods * sT);
        pulse_stop();
        wait_idle();
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R10: reset state
        chk(scl_o && sda_o, "R10", "lines high after reset", int'({scl_o, sda_o}), 3);
        chk(!sda_chg && !mul_err, "R10", "strobe/flag low", int'({sda_chg, mul_err}), 0);
        chk(rate_idx == 0, "R10", "index zero", int'(rate_idx), 0);

        // R1 / R9: idle write applies at once; x1 with an odd period (R5)
        wr_freq(8'h05);
        chk(rate_idx == 6'd5, "R1", "index field", int'(rate_idx), 5);
        xfer(3);

        // R2: factor 2 and factor 4
        wr_freq(8'h48);
        chk(rate_idx == 6'd8, "R1", "index after code 1", int'(rate_idx), 8);
        xfer(3);
        wr_freq(8'h8E);
        xfer(3);
        wr_freq(8'h4D);
        xfer(2);
        chk(!mul_err, "R2", "no flag for codes 0..2", int'(mul_err), 0);

        // R9: deferred write during a transfer
        wr_freq(8'h03);
        pulse_start();
        tick(sSta + sT);
        wr_freq(8'h8A);
        tick(2);
        chk(rate_idx == 6'd3, "R9", "index held while busy", int'(rate_idx), 3);
        pulse_stop();
        wait_idle();
        chk(rate_idx == 6'h0A, "R9", "parked write applied", int'(rate_idx), 10);
        xfer(2);   // runs with factor 4 from the parked write

        // R11: stop while idle, then start while busy
        pulse_stop();
        tick(6);
        chk(scl_o && sda_o, "R11", "stop ignored when idle", int'({scl_o, sda_o}), 3);
        begin
            int f0;
            f0 = n_falls;
            pulse_start();
            tick(sSta + 2 * sT + 1);
            chk(n_falls - f0 >= 2, "R11", "clock still running", n_falls - f0, 2);
            pulse_start();
            tick(sT);
            chk(!sda_o, "R11", "start ignored while busy", int'(sda_o), 0);
        end
        pulse_stop();
        wait_idle();

        // R3: reserved code acts as x1 and latches the flag
        wr_freq(8'hC3);
        chk(mul_err, "R3", "flag on reserved code", int'(mul_err), 1);
        xfer(2);
        wr_freq(8'h05);
        chk(mul_err, "R3", "flag sticky", int'(mul_err), 1);

        // R10 / R3: reset clears the flag
        @(negedge clk); rst_n = 0;
        tick(2); rst_n = 1; tick(1);
        chk(!mul_err && rate_idx == 0, "R10", "reset clears flag and setting",
            int'({mul_err, rate_idx}), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule